// File: doc/BRIEF.md
# Byte-Lane SRAM Strobe Decoder

This block joins a 16-bit big-endian processor bus to a pair of 8-bit asynchronous SRAMs, one wired to the even byte lane (data bits 15:8) and one to the odd byte lane (data bits 7:0). Both SRAM chip enables are tied active on the board. The block switches only their output-enable and write-enable pins, so one bank select from the processor replaces four separate selects. From the bank select, the direction line, the least significant address bit and the 2-bit transfer size code, it drives four active-low strobes and an active-low transfer acknowledge.

The strobes are registered on the system clock, so decode glitches never reach the SRAM pins. A small state machine sequences each access. ST_IDLE moves to ST_SETUP on the first edge that samples the bank select low. ST_SETUP always moves to ST_WAIT on the next edge. ST_WAIT moves to ST_DONE once `WAIT_STATES` cycles have elapsed. ST_DONE holds until the select is released. From ST_SETUP, ST_WAIT or ST_DONE, any edge that samples the select high returns the machine to ST_IDLE. Reset also forces ST_IDLE.

The transfer attributes are captured on the edge that leaves ST_IDLE. The output-enable strobe may assert in ST_SETUP. The write-enable strobe waits until ST_WAIT, which gives the SRAM a full clock of address setup. The default of 14 wait states covers a 70 ns access at a 200 MHz clock.

Top module: `lane_strobe_ctrl`

## Requirements
- R1: While reset is active, and on every clock edge that samples `bank_sel_n` high, all four strobes and `ack_n` are driven high (inactive).
- R2: Output-enable strobes assert only for a transfer captured with `dir_read`=1. Write-enable strobes assert only for a transfer captured with `dir_read`=0.
- R3: The even lane is enabled only when `addr_lsb`=0 and `size_code` is not 2'b11.
- R4: The odd lane is enabled when `addr_lsb`=1 with `size_code`=2'b01 (one byte), or when `addr_lsb`=0 with `size_code` 2'b00 (four bytes) or 2'b10 (two bytes). It is disabled for every other combination.
- R5: `size_code`=2'b11 (three bytes) enables neither lane at either address, yet the transfer is still acknowledged.
- R6: An output-enable strobe goes low on the first edge that samples `bank_sel_n` low. A write-enable strobe goes low no earlier than the second such edge.
- R7: `ack_n` goes low on the (WAIT_STATES+2)-th consecutive edge that samples `bank_sel_n` low, counting the capturing edge as the first, and stays low until `bank_sel_n` is sampled high. A select released earlier produces no acknowledge.
- R8: Direction, address and size are captured on the first select edge. Changes to them later in the same transfer have no effect on the strobes.
- R9: The output-enable and write-enable strobes of one lane are never low at the same time.
- R10: The machine follows ST_IDLE, ST_SETUP, ST_WAIT, ST_DONE as described above, with no path to ST_DONE that skips ST_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel_n | input | 1 | Active-low bank select from the processor |
| dir_read | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_lsb | input | 1 | Address bit 0 (0 = even byte) |
| size_code | input | 2 | Transfer size: 01 byte, 10 word, 11 three bytes, 00 long |
| even_oe_n | output | 1 | Even-lane SRAM output enable, active low |
| even_we_n | output | 1 | Even-lane SRAM write enable, active low |
| odd_oe_n | output | 1 | Odd-lane SRAM output enable, active low |
| odd_we_n | output | 1 | Odd-lane SRAM write enable, active low |
| ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bound checker assumes that `bank_sel_n` is a clean synchronous signal. That is, it changes only between clock edges and is held low for the whole access once asserted. Its setup window and direction-exclusion properties rest on that assumption. The bench drives every input on the falling clock edge, far from the capturing edge. It holds the select low for a bounded number of cycles and sometimes releases it early to abort. It changes direction, address and size in the middle of a transfer only to show that the captured values win. No property depends on those mid-transfer values.

// File: rtl/lane_pkg.sv
package lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;

    typedef struct packed {
        logic is_read;
        logic even_en;
        logic odd_en;
    } xfer_attr_t;

    localparam logic [1:0] SZ_LONG   = 2'b00;
    localparam logic [1:0] SZ_BYTE   = 2'b01;
    localparam logic [1:0] SZ_WORD   = 2'b10;
    localparam logic [1:0] SZ_TRIPLE = 2'b11;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_pkg::*;
(
    input  logic       addr_lsb,
    input  logic [1:0] size_code,
    output logic       even_en,
    output logic       odd_en
);

    // Even lane: even address, any size except the refused triple code
    always_comb begin
        even_en = !addr_lsb && (size_code != SZ_TRIPLE);
    end

    // Odd lane: a single byte at an odd address, or a wide access from an even address
    always_comb begin
        unique case (size_code)
            SZ_BYTE:   odd_en = addr_lsb;
            SZ_WORD,
            SZ_LONG:   odd_en = !addr_lsb;
            SZ_TRIPLE: odd_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int WAIT_STATES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CW = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_STATES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/lane_strobe_ctrl.sv
module lane_strobe_ctrl
    import lane_pkg::*;
#(
    parameter int WAIT_STATES = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bank_sel_n,
    input  logic       dir_read,
    input  logic       addr_lsb,
    input  logic [1:0] size_code,
    output logic       even_oe_n,
    output logic       even_we_n,
    output logic       odd_oe_n,
    output logic       odd_we_n,
    output logic       ack_n
);

    xfer_state_t state_q, state_d;
    xfer_attr_t  attr_q, attr_fresh, attr_use;
    logic        dec_even, dec_odd;
    logic        wait_done;
    logic        oe_phase, we_phase;

    lane_decode u_decode (
        .addr_lsb  (addr_lsb),
        .size_code (size_code),
        .even_en   (dec_even),
        .odd_en    (dec_odd)
    );

    wait_timer #(.WAIT_STATES(WAIT_STATES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_SETUP),
        .run     (state_q == ST_WAIT),
        .expired (wait_done)
    );

    always_comb begin
        attr_fresh.is_read = dir_read;
        attr_fresh.even_en = dec_even;
        attr_fresh.odd_en  = dec_odd;
        attr_use = (state_q == ST_IDLE) ? attr_fresh : attr_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!bank_sel_n) state_d = ST_SETUP;
            ST_SETUP: state_d = bank_sel_n ? ST_IDLE : ST_WAIT;
            ST_WAIT:  state_d = bank_sel_n ? ST_IDLE : (wait_done ? ST_DONE : ST_WAIT);
            ST_DONE:  state_d = bank_sel_n ? ST_IDLE : ST_DONE;
        endcase
    end

    // State register and attribute capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && !bank_sel_n) begin
                attr_q <= attr_fresh;
            end
        end
    end

    always_comb begin
        oe_phase = (state_d != ST_IDLE) && attr_use.is_read;
        we_phase = ((state_d == ST_WAIT) || (state_d == ST_DONE)) && !attr_use.is_read;
    end

    // Registered strobes and acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            even_oe_n <= 1'b1;
            even_we_n <= 1'b1;
            odd_oe_n  <= 1'b1;
            odd_we_n  <= 1'b1;
            ack_n     <= 1'b1;
        end else begin
            even_oe_n <= !(oe_phase && attr_use.even_en);
            even_we_n <= !(we_phase && attr_use.even_en);
            odd_oe_n  <= !(oe_phase && attr_use.odd_en);
            odd_we_n  <= !(we_phase && attr_use.odd_en);
            ack_n     <= !(state_d == ST_DONE);
        end
    end

endmodule

// File: rtl/lane_strobe_chk.sv
module lane_strobe_chk (
    input logic clk,
    input logic rst_n,
    input logic bank_sel_n,
    input logic even_oe_n,
    input logic even_we_n,
    input logic odd_oe_n,
    input logic odd_we_n,
    input logic ack_n
);

    // R1
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bank_sel_n) |-> (even_oe_n && even_we_n && odd_oe_n && odd_we_n && ack_n));

    // R9
    even_lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!even_oe_n && !even_we_n));

    // R9
    odd_lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!odd_oe_n && !odd_we_n));

    // R2
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((!even_oe_n || !odd_oe_n) && (!even_we_n || !odd_we_n)));

    // R6
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!even_we_n || !odd_we_n) |-> (!$past(bank_sel_n) && !$past(bank_sel_n, 2)));

    // R7
    ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> (!$past(bank_sel_n) && !$past(bank_sel_n, 2)));

endmodule

bind lane_strobe_ctrl lane_strobe_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_sel_n (bank_sel_n),
    .even_oe_n  (even_oe_n),
    .even_we_n  (even_we_n),
    .odd_oe_n   (odd_oe_n),
    .odd_we_n   (odd_we_n),
    .ack_n      (ack_n)
);

// File: tb/lane_strobe_ctrl_test.sv
`timescale 1ns/1ps
module lane_strobe_ctrl_test;

    localparam int W = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel_n = 1'b1;
    logic       dir_read = 1'b1;
    logic       addr_lsb = 1'b0;
    logic [1:0] size_code = 2'b01;
    logic       even_oe_n, even_we_n, odd_oe_n, odd_we_n, ack_n;

    int    checks = 0;
    int    failures = 0;
    bit    compare_on = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    lane_strobe_ctrl #(.WAIT_STATES(W)) uut (
        .clk(clk), .rst_n(rst_n), .bank_sel_n(bank_sel_n), .dir_read(dir_read),
        .addr_lsb(addr_lsb), .size_code(size_code),
        .even_oe_n(even_oe_n), .even_we_n(even_we_n),
        .odd_oe_n(odd_oe_n), .odd_we_n(odd_we_n), .ack_n(ack_n)
    );

    // Behavioural reference: edges since the select was first seen low
    bit m_active = 1'b0;
    bit m_read, m_even, m_odd;
    int m_n = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 1'b0;
        end else if (bank_sel_n) begin
            m_active = 1'b0;
        end else if (!m_active) begin
            m_active = 1'b1;
            m_n = 0;
            m_read = dir_read;
            m_even = (addr_lsb == 1'b0) && (size_code != 2'b11);
            m_odd  = (addr_lsb == 1'b1 && size_code == 2'b01) ||
                     (addr_lsb == 1'b0 && (size_code == 2'b00 || size_code == 2'b10));
        end else begin
            m_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on && !finished) begin
            bit e_eoe, e_ewe, e_ooe, e_owe, e_ack;
            e_eoe = !(m_active && m_read && m_even);
            e_ewe = !(m_active && !m_read && m_even && m_n >= 1);
            e_ooe = !(m_active && m_read && m_odd);
            e_owe = !(m_active && !m_read && m_odd && m_n >= 1);
            e_ack = !(m_active && m_n >= W + 1);
            check(even_oe_n == e_eoe, cur_req, "even_oe_n", even_oe_n, e_eoe);
            check(even_we_n == e_ewe, cur_req, "even_we_n", even_we_n, e_ewe);
            check(odd_oe_n == e_ooe, cur_req, "odd_oe_n", odd_oe_n, e_ooe);
            check(odd_we_n == e_owe, cur_req, "odd_we_n", odd_we_n, e_owe);
            check(ack_n == e_ack, cur_req, "ack_n", ack_n, e_ack);
            // R9: one lane never reads and writes at once
            check(!(!even_oe_n && !even_we_n) && !(!odd_oe_n && !odd_we_n),
                  "R9", "lane oe/we overlap", 0, 0);
        end
    end

    task automatic transfer(input bit rd, input bit a0, input logic [1:0] sz, input int hold);
        @(negedge clk);
        dir_read = rd; addr_lsb = a0; size_code = sz; bank_sel_n = 1'b0;
        repeat (hold) @(negedge clk);
        bank_sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 / R10: reset state
        repeat (3) @(negedge clk);
        check({even_oe_n, even_we_n, odd_oe_n, odd_we_n, ack_n} == 5'b11111,
              "R1", "outputs in reset", {even_oe_n, even_we_n, odd_oe_n, odd_we_n, ack_n}, 31);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1'b1;
        cur_req = "R10";
        repeat (2) @(negedge clk);

        // R2, R3, R4, R5: full sweep of direction, address and size
        for (int rd = 0; rd < 2; rd++) begin
            for (int a = 0; a < 2; a++) begin
                for (int s = 0; s < 4; s++) begin
                    cur_req = (s == 3) ? "R5" : (a == 1 ? "R4" : "R3");
                    transfer(rd[0], a[0], s[1:0], W + 5);
                end
            end
        end

        // R6: write strobe timing
        cur_req = "R6";
        @(negedge clk);
        dir_read = 1'b0; addr_lsb = 1'b0; size_code = 2'b10; bank_sel_n = 1'b0;
        @(negedge clk);
        check(even_we_n == 1'b1 && odd_we_n == 1'b1, "R6", "we after first edge", even_we_n, 1);
        @(negedge clk);
        check(even_we_n == 1'b0 && odd_we_n == 1'b0, "R6", "we after second edge", even_we_n, 0);
        repeat (W + 2) @(negedge clk);
        bank_sel_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: read output enable on first edge
        @(negedge clk);
        dir_read = 1'b1; addr_lsb = 1'b1; size_code = 2'b01; bank_sel_n = 1'b0;
        @(negedge clk);
        check(odd_oe_n == 1'b0 && even_oe_n == 1'b1, "R2", "odd read oe", odd_oe_n, 0);
        repeat (W + 2) @(negedge clk);
        bank_sel_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: acknowledge latency and hold
        cur_req = "R7";
        begin
            int lat = 0;
            @(negedge clk);
            dir_read = 1'b1; addr_lsb = 1'b0; size_code = 2'b00; bank_sel_n = 1'b0;
            do begin
                @(negedge clk);
                lat++;
            end while (ack_n && lat < 100);
            check(lat == W + 2, "R7", "ack latency", lat, W + 2);
            repeat (5) @(negedge clk);
            check(ack_n == 1'b0, "R7", "ack held", ack_n, 0);
            bank_sel_n = 1'b1;
            @(negedge clk);
            check(ack_n == 1'b1, "R1", "ack released", ack_n, 1);
            repeat (2) @(negedge clk);
        end

        // R7: aborted transfers never acknowledge
        transfer(1'b0, 1'b0, 2'b01, 1);
        transfer(1'b1, 1'b0, 2'b10, 2);
        transfer(1'b0, 1'b1, 2'b01, W);

        // R8: mid-transfer attribute changes are ignored
        cur_req = "R8";
        @(negedge clk);
        dir_read = 1'b0; addr_lsb = 1'b0; size_code = 2'b01; bank_sel_n = 1'b0;
        repeat (3) @(negedge clk);
        dir_read = 1'b1; addr_lsb = 1'b1; size_code = 2'b00;
        repeat (W + 3) @(negedge clk);
        check(even_we_n == 1'b0 && odd_oe_n == 1'b1, "R8", "captured write kept", even_we_n, 0);
        bank_sel_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: back-to-back transfers return through idle
        cur_req = "R10";
        transfer(1'b1, 1'b0, 2'b11, W + 4);
        transfer(1'b0, 1'b0, 2'b00, W + 4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule